// File: doc/BRIEF.md
# Broadcast Command Receiver with Offset

This block sits on the receive side of a distribution module. A 23-bit command word arrives with each bunch-crossing pulse. The block compares the word's two 6-bit address fields with the module's own cluster and daughter codes, and a zero field acts as a broadcast value. Words that pass are written into an 8-slot circular memory. Words that fail are written as zeros.

On every crossing the block reads back the word stored a programmable number of crossings earlier (0 to 7). A 2-bit selector picks the clock at which that word is latched onto the output, which allows for cable delay. At the same point the block masks the word's 8-bit trigger field and reduces it to a single trigger-found flag.

Word layout: bits [22:17] hold the cluster field, bits [16:11] the daughter field, bits [10:3] the trigger field and bits [2:0] a free tag. Crossing pulses last one clock and are at least four clocks apart.

Top module: `cmd_rx_top`

## Requirements
- R1: The cluster field [22:17] matches when it equals `loc_cluster_i` or is zero. The daughter field [16:11] matches when it equals `loc_daughter_i` or is zero. A hit needs both fields to match.
- R2: `hit_o` takes the hit result of the word sampled at a crossing-pulse edge. It keeps that value until the next pulse.
- R3: A word without a hit is stored as all zeros. It later appears at `data_o` as zero with `trig_found_o` low.
- R4: Each pulse writes its word into the next of 8 slots, wrapping after the last. The pulse then reads the word of the pulse `offset_i` crossings earlier. An offset of 0 returns the word just written. Slots not written since reset read as zero.
- R5: Let k = min(`stage_sel_i`, 2). The word is latched at the (k+1)-th rising edge after the edge that sampled the pulse. `data_valid_o` is high for exactly the one clock after that edge. Selector values 2 and 3 behave the same.
- R6: `data_o` and `trig_found_o` change only together with a `data_valid_o` pulse. They hold their values in between.
- R7: `trig_found_o` is the OR of (latched trigger field [10:3] AND `trig_mask_i`).
- R8: During and right after reset, `hit_o`, `data_valid_o`, `data_o` and `trig_found_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_pulse_i | input | 1 | Crossing pulse, one clock wide |
| cmd_word_i | input | 23 | Command word, valid with the pulse |
| loc_cluster_i | input | 6 | Local cluster code |
| loc_daughter_i | input | 6 | Local daughter code |
| offset_i | input | 3 | Delay in crossings |
| stage_sel_i | input | 2 | Latch stage selector |
| trig_mask_i | input | 8 | Trigger field mask |
| hit_o | output | 1 | Address hit of the last pulse |
| data_valid_o | output | 1 | One-clock strobe for a new delayed word |
| data_o | output | 23 | Delayed, latched word |
| trig_found_o | output | 1 | Masked trigger flag of the latched word |

## Verification
With an offset of zero, the write of the incoming word and the read of the delayed word land on the same memory slot within one crossing. The read must return the new word, not the stale one. The bench provokes this by running the first scenarios at offset zero, with addresses that hit and addresses that miss. It judges the result by requiring `data_o` to equal the word just sent, or zero for a miss. A later burst at offsets 3 and 7 wraps the slot pointer. That burst shows the same slot being overwritten while older slots are still being read.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
  localparam int WORD_W   = 23;
  localparam int CODE_W   = 6;
  localparam int TRIG_W   = 8;
  localparam int CLU_LSB  = 17;
  localparam int DAU_LSB  = 11;
  localparam int TRIG_LSB = 3;
endpackage

// File: rtl/addr_match.sv
module addr_match #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] cluster_i,
  input  logic [CODE_W-1:0] daughter_i,
  input  logic [CODE_W-1:0] loc_cluster_i,
  input  logic [CODE_W-1:0] loc_daughter_i,
  output logic              hit_o
);
  logic clu_ok, dau_ok;

  always_comb begin
    clu_ok = (cluster_i == '0) || (cluster_i == loc_cluster_i);
    dau_ok = (daughter_i == '0) || (daughter_i == loc_daughter_i);
    hit_o  = clu_ok && dau_ok;
  end
endmodule

// File: rtl/delay_ring.sv
module delay_ring #(
  parameter int WORD_W = 23,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  offset_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q;
  logic [PTR_W-1:0]  rd_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      rd_idx_q <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_ptr_q] <= wr_data_i;
      wr_ptr_q        <= wr_ptr_q + 1'b1;
      rd_idx_q        <= wr_ptr_q - offset_i;  // read after write: offset 0 = new word
    end
  end

  assign rd_data_o = mem_q[rd_idx_q];

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> wr_ptr_q == $past(wr_ptr_q) + 1'b1);
  a_r4_ptr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_q));
endmodule

// File: rtl/phase_latch.sv
module phase_latch #(
  parameter int WORD_W   = 23,
  parameter int TRIG_W   = 8,
  parameter int TRIG_LSB = 3,
  parameter int SEL_W    = 2,
  parameter int N_STAGE  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic [TRIG_W-1:0] mask_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              trig_found_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_STAGE - 1);

  logic [SEL_W-1:0] sel_eff;
  logic [SEL_W-1:0] cnt_q;
  logic             busy_q;

  assign sel_eff = (sel_i > LAST) ? LAST : sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      busy_q       <= 1'b0;
      valid_o      <= 1'b0;
      data_o       <= '0;
      trig_found_o <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= sel_eff;
      busy_q  <= 1'b1;
      valid_o <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        data_o       <= din_i;
        trig_found_o <= |(din_i[TRIG_LSB +: TRIG_W] & mask_i);
        valid_o      <= 1'b1;
        busy_q       <= 1'b0;
      end else begin
        cnt_q   <= cnt_q - 1'b1;
        valid_o <= 1'b0;
      end
    end else begin
      valid_o <= 1'b0;
    end
  end

  a_r5_stage0_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sel_i == '0) |=> ##1 valid_o);
  a_r5_no_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);
  a_r5_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(trig_found_o)));
endmodule

// File: rtl/cmd_rx_top.sv
module cmd_rx_top
  import cmd_rx_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int N_STAGE = 3,
  localparam int OFF_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bx_pulse_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic [CODE_W-1:0] loc_cluster_i,
  input  logic [CODE_W-1:0] loc_daughter_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [1:0]        stage_sel_i,
  input  logic [TRIG_W-1:0] trig_mask_i,
  output logic              hit_o,
  output logic              data_valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              trig_found_o
);
  logic              hit_c;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;

  addr_match #(.CODE_W(CODE_W)) u_match (
    .cluster_i      (cmd_word_i[CLU_LSB +: CODE_W]),
    .daughter_i     (cmd_word_i[DAU_LSB +: CODE_W]),
    .loc_cluster_i  (loc_cluster_i),
    .loc_daughter_i (loc_daughter_i),
    .hit_o          (hit_c)
  );

  assign wr_word = hit_c ? cmd_word_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hit_o <= 1'b0;
    else if (bx_pulse_i) hit_o <= hit_c;
  end

  delay_ring #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (bx_pulse_i),
    .wr_data_i (wr_word),
    .offset_i  (offset_i),
    .rd_data_o (rd_word)
  );

  phase_latch #(
    .WORD_W(WORD_W), .TRIG_W(TRIG_W), .TRIG_LSB(TRIG_LSB),
    .SEL_W(2), .N_STAGE(N_STAGE)
  ) u_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (bx_pulse_i),
    .sel_i        (stage_sel_i),
    .din_i        (rd_word),
    .mask_i       (trig_mask_i),
    .data_o       (data_o),
    .valid_o      (data_valid_o),
    .trig_found_o (trig_found_o)
  );

  a_r2_hit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_pulse_i |=> $stable(hit_o));
  a_r1_broadcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bx_pulse_i && cmd_word_i[CLU_LSB +: CODE_W] == '0
                && cmd_word_i[DAU_LSB +: CODE_W] == '0) |=> hit_o);
endmodule

// File: tb/cmd_rx_top_tb_top.sv
module cmd_rx_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bx = 1'b0;
  logic [22:0] cmd = '0;
  logic [5:0]  loc_clu = 6'd5;
  logic [5:0]  loc_dau = 6'd9;
  logic [2:0]  off = '0;
  logic [1:0]  sel = '0;
  logic [7:0]  mask = 8'hFF;
  logic        hit_o, data_valid_o, trig_found_o;
  logic [22:0] data_o;

  cmd_rx_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bx_pulse_i(bx), .cmd_word_i(cmd),
    .loc_cluster_i(loc_clu), .loc_daughter_i(loc_dau), .offset_i(off),
    .stage_sel_i(sel), .trig_mask_i(mask), .hit_o(hit_o),
    .data_valid_o(data_valid_o), .data_o(data_o), .trig_found_o(trig_found_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [22:0] data;
    logic        trig;
    int          when;
  } exp_t;
  exp_t exp_q[$];

  int drv_checks = 0, drv_errs = 0;
  int mon_checks = 0, mon_errs = 0;

  logic [22:0] model_mem [8];
  int          model_wp = 0;
  logic [22:0] last_data = '0;
  logic        last_trig = 1'b0;

  function automatic logic [22:0] mk(input logic [5:0] c, input logic [5:0] d,
                                     input logic [7:0] t, input logic [2:0] g);
    return {c, d, t, g};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    drv_checks++;
    if (!ok) begin
      drv_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [22:0] w);
    logic       h;
    logic [22:0] rd;
    int k;
    exp_t e;
    // R6: outputs unchanged since the last strobe
    chk(data_o == last_data && trig_found_o == last_trig, "R6 hold",
        {8'h0, data_o, trig_found_o}, {8'h0, last_data, last_trig});
    h = ((w[22:17] == 0) || (w[22:17] == loc_clu)) &&
        ((w[16:11] == 0) || (w[16:11] == loc_dau));
    model_mem[model_wp] = h ? w : '0;
    rd = model_mem[(model_wp - int'(off)) & 7];
    model_wp = (model_wp + 1) % 8;
    k = (sel > 2) ? 2 : int'(sel);
    e.data = rd;
    e.trig = |(rd[10:3] & mask);
    e.when = cyc + k + 2;
    exp_q.push_back(e);
    bx = 1'b1; cmd = w;
    @(negedge clk);
    bx = 1'b0; cmd = '0;
    chk(hit_o == h, "R1/R2 hit", 32'(hit_o), 32'(h));
    repeat (5) @(negedge clk);
    chk(hit_o == h, "R2 hit held", 32'(hit_o), 32'(h));
  endtask

  always @(negedge clk) begin
    if (rst_n && data_valid_o) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_errs++;
        $display("FAIL R5 spurious strobe actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (cyc != e.when) begin
          mon_errs++;
          $display("FAIL R5 strobe cycle actual=%0d expected=%0d", cyc, e.when);
        end
        mon_checks++;
        if (data_o != e.data) begin
          mon_errs++;
          $display("FAIL R3/R4 data actual=%h expected=%h", data_o, e.data);
        end
        mon_checks++;
        if (trig_found_o != e.trig) begin
          mon_errs++;
          $display("FAIL R7 trig actual=%b expected=%b", trig_found_o, e.trig);
        end
        last_data = data_o;
        last_trig = trig_found_o;
      end
    end
  end

  task automatic finish_run(input bit timeout);
    int errs;
    errs = drv_errs + mon_errs;
    if (timeout) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors",
             drv_checks + mon_checks + (timeout ? 1 : 0), errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    finish_run(1'b1);
  end

  initial begin
    for (int i = 0; i < 8; i++) model_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reset values
    chk(hit_o == 0 && data_valid_o == 0 && data_o == 0 && trig_found_o == 0,
        "R8 reset", {8'h0, data_o, hit_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit_o == 0 && data_valid_o == 0 && data_o == 0 && trig_found_o == 0,
        "R8 after reset", {8'h0, data_o, hit_o}, 32'h0);

    // R1/R4 offset 0: write and read of same slot in one crossing
    send(mk(6'd5, 6'd9, 8'h81, 3'd3));
    send(mk(6'd0, 6'd9, 8'h02, 3'd1));
    send(mk(6'd5, 6'd0, 8'h00, 3'd2));
    send(mk(6'd0, 6'd0, 8'h40, 3'd7));
    // R3: misses stored as zero
    send(mk(6'd6, 6'd9, 8'hFF, 3'd5));
    send(mk(6'd5, 6'd10, 8'hFF, 3'd5));
    send(mk(6'd1, 6'd2, 8'hFF, 3'd5));
    // R5: stage selection
    sel = 2'd1; send(mk(6'd5, 6'd9, 8'h11, 3'd1));
    sel = 2'd2; send(mk(6'd5, 6'd9, 8'h22, 3'd2));
    sel = 2'd3; send(mk(6'd5, 6'd9, 8'h33, 3'd3));
    sel = 2'd0;
    // R4: offsets with wrap
    off = 3'd3;
    for (int i = 0; i < 10; i++)
      send(mk(6'd5, (i % 3 == 2) ? 6'd4 : 6'd9, 8'(i * 17 + 1), 3'(i)));
    off = 3'd7; sel = 2'd1;
    for (int i = 0; i < 9; i++)
      send(mk(6'd0, 6'd9, 8'(8'h80 >> (i % 8)), 3'(i)));
    // R7: masking
    off = 3'd0; sel = 2'd0;
    mask = 8'h00; send(mk(6'd5, 6'd9, 8'hFF, 3'd0));
    mask = 8'h10; send(mk(6'd5, 6'd9, 8'h10, 3'd0));
    send(mk(6'd5, 6'd9, 8'hEF, 3'd0));
    // R1: new local codes
    loc_clu = 6'd63; loc_dau = 6'd1; mask = 8'hFF;
    send(mk(6'd63, 6'd1, 8'h01, 3'd4));
    send(mk(6'd5, 6'd9, 8'h01, 3'd4));
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all strobes seen", 32'(exp_q.size()), 32'h0);
    finish_run(1'b0);
  end
endmodule